// File: doc/BRIEF.md
# Stuffing Check Error Latch

This block checks the positive-stuffing decision of a multiplexer frame against a magnitude comparison. When the frame is at word 28, a stuff indication is present and the comparator reports A greater than B, the block raises a one-cycle stuffing error pulse. That pulse, and an external active-low error input, feed two sticky diagnostic flags. Both flags stay set until an error-reset request arrives. That request is shared by the end of a self-test run and by an operator's display-reset action.

A self-test input, active low and synchronised to the clock, forces both diagnostic flags on for as long as it is held. Self-test takes priority over the error-reset. An error-reset clears the flags at the next edge. An external error that is still present then sets the hold flag again one clock later. The trip flag follows stuffing errors and self-test only. The hold flag also follows the external error input. A separate power-on reset initialises the synchronisers and the flags.

Top module: `stuff_chk_diag`

## Requirements
- R1: While `rst_n` is low, and at its release, `stuff_err`, `diag_hold` and `diag_trip` are 0.
- R2: `stuff_err` is 1 for exactly the cycle after a rising edge at which `word28`, `stuff_ind` and `a_gt_b` are all 1.
- R3: `stuff_err` stays 0 after an edge at which any one of `word28`, `stuff_ind` or `a_gt_b` is 0.
- R4: A `stuff_err` pulse sets both `diag_trip` and `diag_hold` at the next edge. Both then stay set without any further error until an error-reset.
- R5: `ext_err_n` held low sets `diag_hold` on the third edge after the change, which is SYNC_STAGES+1 edges with the default of 2. It never sets `diag_trip`.
- R6: `self_test_n` held low forces `diag_trip` and `diag_hold` to 1 from the third edge after the change (SYNC_STAGES+1), for as long as it stays low.
- R7: `err_rst` high at an edge, with self-test not active, clears both `diag_trip` and `diag_hold` at that edge.
- R8: When self-test is active and `err_rst` is high at the same edge, both flags remain 1.
- R9: An external error still active when an error-reset clears the flags sets `diag_hold` again at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| err_rst | input | 1 | Error-reset request (end of self-test or display reset), active high, synchronous |
| self_test_n | input | 1 | Self-test request, active low, asynchronous to clk |
| ext_err_n | input | 1 | Other error source for the diagnostic OR, active low, asynchronous to clk |
| word28 | input | 1 | Word-28 time strobe |
| stuff_ind | input | 1 | Positive-stuff indication |
| a_gt_b | input | 1 | Comparator result, 1 when A exceeds B |
| stuff_err | output | 1 | One-cycle stuffing error pulse |
| diag_hold | output | 1 | Sticky diagnostic flag fed by any error or self-test |
| diag_trip | output | 1 | Sticky diagnostic flag fed by stuffing errors or self-test |

## Verification
The bench drives each single-input miss of the three-way qualification. A design that dropped one term would flag errors outside word 28 or without a stuff decision. It holds an external error across an error-reset. A design that let the live error beat the reset would never show the cleared cycle, and one that lost the error would never set the flag again. It raises the error-reset during self-test to expose a wrong priority, which would drop the flags while self-test is still active. It also checks that the external error leaves the trip flag alone, and that both flags hold after the stimulus has gone.

// File: rtl/stuff_chk_diag.sv
module stuff_chk_diag #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_rst,
  input  logic self_test_n,
  input  logic ext_err_n,
  input  logic word28,
  input  logic stuff_ind,
  input  logic a_gt_b,
  output logic stuff_err,
  output logic diag_hold,
  output logic diag_trip
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] st_sync, ex_sync;
  logic st_act, ex_act, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sync[0] <= 1'b1;
      ex_sync[0] <= 1'b1;
    end else begin
      st_sync[0] <= self_test_n;
      ex_sync[0] <= ext_err_n;
    end
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_sync[i] <= 1'b1;
          ex_sync[i] <= 1'b1;
        end else begin
          st_sync[i] <= st_sync[i-1];
          ex_sync[i] <= ex_sync[i-1];
        end
      end
    end
  endgenerate

  assign st_act = ~st_sync[LAST];
  assign ex_act = ~ex_sync[LAST];
  assign hit    = word28 & stuff_ind & a_gt_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stuff_err <= 1'b0;
      diag_hold <= 1'b0;
      diag_trip <= 1'b0;
    end else begin
      stuff_err <= hit;
      if (st_act) begin
        diag_hold <= 1'b1;
        diag_trip <= 1'b1;
      end else if (err_rst) begin
        diag_hold <= 1'b0;
        diag_trip <= 1'b0;
      end else begin
        diag_hold <= diag_hold | stuff_err | ex_act;
        diag_trip <= diag_trip | stuff_err;
      end
    end
  end

endmodule

module stuff_chk_diag_sva (
  input logic clk,
  input logic rst_n,
  input logic err_rst,
  input logic word28,
  input logic stuff_ind,
  input logic a_gt_b,
  input logic st_act,
  input logic ex_act,
  input logic stuff_err,
  input logic diag_hold,
  input logic diag_trip
);

  a_r2_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (word28 && stuff_ind && a_gt_b) |=> stuff_err);

  a_r3_no_false_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !(word28 && stuff_ind && a_gt_b) |=> !stuff_err);

  a_r4_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
    (stuff_err && !err_rst) |=> (diag_trip && diag_hold));

  a_r4_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_trip && !err_rst) |=> diag_trip);

  a_r4_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_hold && !err_rst) |=> diag_hold);

  a_r5_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_act && !err_rst) |=> diag_hold);

  a_r5_ext_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_trip && !stuff_err && !st_act) |=> !diag_trip);

  a_r8_selftest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    st_act |=> (diag_trip && diag_hold));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rst && !st_act) |=> (!diag_trip && !diag_hold));

endmodule

bind stuff_chk_diag stuff_chk_diag_sva u_sva (
  .clk(clk), .rst_n(rst_n), .err_rst(err_rst), .word28(word28),
  .stuff_ind(stuff_ind), .a_gt_b(a_gt_b), .st_act(st_act), .ex_act(ex_act),
  .stuff_err(stuff_err), .diag_hold(diag_hold), .diag_trip(diag_trip)
);

// File: tb/sim_stuff_chk_diag.sv
module sim_stuff_chk_diag;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_rst = 1'b0, self_test_n = 1'b1, ext_err_n = 1'b1;
  logic word28 = 1'b0, stuff_ind = 1'b0, a_gt_b = 1'b0;
  logic stuff_err, diag_hold, diag_trip;

  int checks = 0, failures = 0;
  bit m_stuff, m_hold, m_trip;
  bit stq[$], exq[$];

  always #2.5 clk = ~clk;

  stuff_chk_diag u0 (
    .clk(clk), .rst_n(rst_n), .err_rst(err_rst), .self_test_n(self_test_n),
    .ext_err_n(ext_err_n), .word28(word28), .stuff_ind(stuff_ind),
    .a_gt_b(a_gt_b), .stuff_err(stuff_err), .diag_hold(diag_hold),
    .diag_trip(diag_trip)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stuff = 0; m_hold = 0; m_trip = 0;
      stq = '{1'b1, 1'b1};
      exq = '{1'b1, 1'b1};
    end else begin
      bit st_on, ex_on, nh, nt;
      st_on = (stq[0] == 1'b0);
      ex_on = (exq[0] == 1'b0);
      if (st_on) begin nh = 1; nt = 1; end
      else if (err_rst) begin nh = 0; nt = 0; end
      else begin nh = m_hold | m_stuff | ex_on; nt = m_trip | m_stuff; end
      m_hold = nh; m_trip = nt;
      m_stuff = word28 & stuff_ind & a_gt_b;
      void'(stq.pop_front()); stq.push_back(self_test_n);
      void'(exq.pop_front()); exq.push_back(ext_err_n);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2/R3 model stuff_err", stuff_err, m_stuff);
    chk("R4/R5/R6/R7 model diag_hold", diag_hold, m_hold);
    chk("R4/R6/R7 model diag_trip", diag_trip, m_trip);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    err_rst = 1; cyc(1); err_rst = 0;
  endtask

  initial begin
    fork
      begin
        cyc(3);
        chk("R1 reset stuff_err", stuff_err, 1'b0);
        chk("R1 reset diag_hold", diag_hold, 1'b0);
        chk("R1 reset diag_trip", diag_trip, 1'b0);
        rst_n = 1; cyc(2);
        chk("R1 after release diag_hold", diag_hold, 1'b0);

        word28 = 1; stuff_ind = 1; a_gt_b = 1; cyc(1);
        chk("R2 pulse high", stuff_err, 1'b1);
        word28 = 0; stuff_ind = 0; a_gt_b = 0; cyc(1);
        chk("R2 pulse one cycle", stuff_err, 1'b0);
        chk("R4 trip set", diag_trip, 1'b1);
        chk("R4 hold set", diag_hold, 1'b1);
        cyc(5);
        chk("R4 trip sticky", diag_trip, 1'b1);
        chk("R4 hold sticky", diag_hold, 1'b1);
        clear_flags();
        chk("R7 trip cleared", diag_trip, 1'b0);
        chk("R7 hold cleared", diag_hold, 1'b0);

        for (int k = 0; k < 8; k++) begin
          word28 = k[0]; stuff_ind = k[1]; a_gt_b = k[2];
          if (k != 7) begin
            cyc(1);
            chk("R3 miss no pulse", stuff_err, 1'b0);
          end
        end
        word28 = 0; stuff_ind = 1; a_gt_b = 1; cyc(6);
        chk("R3 outside word 28 no pulse", stuff_err, 1'b0);
        chk("R3 outside word 28 no trip", diag_trip, 1'b0);
        stuff_ind = 0; a_gt_b = 0;

        ext_err_n = 0; cyc(2);
        chk("R5 hold not yet", diag_hold, 1'b0);
        cyc(1);
        chk("R5 hold set by ext", diag_hold, 1'b1);
        chk("R5 trip untouched", diag_trip, 1'b0);
        clear_flags();
        chk("R7 hold cleared with live error", diag_hold, 1'b0);
        cyc(1);
        chk("R9 hold re-set by live error", diag_hold, 1'b1);
        ext_err_n = 1; cyc(4);
        chk("R5 hold sticky after ext gone", diag_hold, 1'b1);
        chk("R5 trip still clear", diag_trip, 1'b0);
        clear_flags();
        chk("R7 hold cleared", diag_hold, 1'b0);

        self_test_n = 0; cyc(3);
        chk("R6 trip forced", diag_trip, 1'b1);
        chk("R6 hold forced", diag_hold, 1'b1);
        err_rst = 1; cyc(2);
        chk("R8 trip kept under reset", diag_trip, 1'b1);
        chk("R8 hold kept under reset", diag_hold, 1'b1);
        err_rst = 0; self_test_n = 1; cyc(3);
        chk("R6 trip held after self-test", diag_trip, 1'b1);
        clear_flags();
        chk("R7 trip cleared after self-test", diag_trip, 1'b0);
        chk("R7 hold cleared after self-test", diag_hold, 1'b0);

        word28 = 1; stuff_ind = 1; a_gt_b = 1; err_rst = 1; cyc(1);
        word28 = 0; cyc(1);
        chk("R2 pulse during reset", stuff_err, 1'b0);
        chk("R7 reset clears flag under pulse", diag_trip, 1'b0);
        err_rst = 0; stuff_ind = 0; a_gt_b = 0; cyc(1);
        chk("R4 no set after pulse ends", diag_trip, 1'b0);
        cyc(3);
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule